// File: doc/BRIEF.md
# Stream-Cipher Reset and Substitution-Table Initializer

This block controls reset and start-up for one stream-cipher engine. Software reaches it over a simple register bus, and it offers three reset levels that act on this engine only. The lightest level clears pending interrupts. The middle level re-initialises the engine but keeps the interrupt mask. The heaviest level acts like the hardware reset pin and returns every register to its reset value.

The two heavier levels, and the hardware reset, start a fill of the 256-entry substitution table. The fill writes each entry with its own index, one entry per clock. A ready bit in the status word stays low until the fill is finished. A second port reads the table, and that port stands in for the cipher datapath.

The status word is read-only. A bus write to it is treated as an address error, which sets a flag in the interrupt status word. Each interrupt flag drives its interrupt output only while the matching mask bit is set.

Top module: `cipher_reset_ctrl`

## Requirements
- R1: After hardware reset (`rst` high at a clock edge):
  - the interrupt status and mask words read 0;
  - both interrupt outputs are low;
  - read data is 0.
- R2: The bus addresses are: 0 = reset control, 1 = status, 2 = interrupt status, 3 = interrupt mask. In the control word:
  - bit 61 requests an interrupt clear;
  - bit 62 requests module initialization;
  - bit 63 requests a full reset;
  - all other bits are ignored.

  The control word always reads 0, because each request clears itself.
- R3: A fill starts on the first edge after a reset request: either the last edge with `rst` high, or the edge that accepts the control write. The fill writes table entry i with value i, for i = 0 to 255, one entry per edge over 256 edges. Status bit 0 (ready) is low during the fill and high after the 256th write edge. A status read therefore first returns 1 when it is issued on the 257th edge after the request.
- R4: A full reset (control bit 63) does the following:
  - clears the interrupt status word;
  - clears the mask word;
  - clears the ready bit;
  - clears the read data;
  - restarts the fill.
- R5: Module initialization (control bit 62) does everything a full reset does, except that the mask word keeps its value.
- R6: When control bits 62 and 63 are written together, the full reset applies and the mask word is cleared.
- R7: An interrupt clear (control bit 61) zeroes the interrupt status word and both interrupt outputs. It does not restart the fill, and ready stays unchanged.
- R8: A write to the status address sets interrupt status bit 1 (address error). The status contents do not change.
- R9: `irq_done` equals interrupt status bit 0 AND mask bit 0. `irq_err` equals interrupt status bit 1 AND mask bit 1. Both are registered and follow the register values of the same edge.
- R10: A write to the interrupt status address clears each bit that is written as 1. If a flag is set and cleared on the same edge, the set wins. This applies to a clear by write-1 and to a clear by interrupt clear.
- R11: Read data appears on the edge that samples `bus_rd` and holds until the next read or reset. Reads of unmapped addresses return 0. Writes to unmapped addresses change nothing.
- R12: Interrupt status bit 0 is set on the edge that writes the last table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_done | output | 1 | Masked fill-complete interrupt |
| irq_err | output | 1 | Masked address-error interrupt |
| sbox_raddr | input | log2(SBOX_DEPTH) | Table read address |
| sbox_rdata | output | SBOX_W | Table read data, one cycle after the address |

## Verification
Two events can land on the same edge: the fill completing, which sets interrupt status bit 0, and a software clear of that bit, either by a write-1 to the interrupt status word or by an interrupt clear request. The bench provokes this by issuing module initialization, idling exactly 255 cycles, and placing the clear on the 256th edge. The bench's cycle model applies the set-wins rule, so `irq_done` must be high afterwards and the interrupt status word must read 1. The bench runs this once for each clear source.

// File: rtl/cre_pkg.sv
package cre_pkg;
  // register word addresses
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_ISR  = 2;
  localparam int REG_IMR  = 3;

  // control word request bits
  localparam int CTRL_IRQ_CLR  = 61;
  localparam int CTRL_MOD_INIT = 62;
  localparam int CTRL_FULL_RST = 63;

  // status and interrupt bit positions
  localparam int STAT_READY = 0;
  localparam int IRQ_DONE   = 0;
  localparam int IRQ_AERR   = 1;
  localparam int NUM_IRQ    = 2;

  typedef struct packed {
    logic full;
    logic module_init;
    logic irq_clear;
  } rst_req_t;
endpackage

// File: rtl/cre_ctrl_decode.sv
module cre_ctrl_decode
  import cre_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              hw_rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        req_bits,   // control bits 63..61
  output rst_req_t          req,
  output logic              restart
);
  logic ctrl_hit;

  always_comb begin
    ctrl_hit        = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
    // full reset has priority over module init
    req.full        = hw_rst || (ctrl_hit && req_bits[2]);
    req.module_init = ctrl_hit && req_bits[1] && !req.full;
    req.irq_clear   = ctrl_hit && req_bits[0];
    restart         = req.full || req.module_init;
  end
endmodule

// File: rtl/cre_sbox_fill.sv
module cre_sbox_fill #(
  parameter  int DEPTH = 256,
  parameter  int WIDTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             restart,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [WIDTH-1:0] wr_val,
  output logic             ready,
  output logic             fill_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic             busy_q;
  logic             ready_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (restart) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
      idx_q   <= '0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
      end
    end
  end

  assign wr_en    = busy_q;
  assign wr_idx   = idx_q;
  assign wr_val   = WIDTH'(idx_q);
  assign ready    = ready_q;
  assign fill_end = busy_q && (idx_q == LAST);
endmodule

// File: rtl/cre_sbox_ram.sv
module cre_sbox_ram #(
  parameter  int DEPTH = 256,
  parameter  int WIDTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual port, read-before-write, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cre_regs.sv
module cre_regs
  import cre_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  rst_req_t           req,
  input  logic               restart,
  input  logic               fill_end,
  input  logic               ready,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_IRQ-1:0] wdata_lo,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_IRQ-1:0] irq,
  output logic [NUM_IRQ-1:0] isr_bits,
  output logic [NUM_IRQ-1:0] imr_bits
);
  logic [NUM_IRQ-1:0] isr_q, imr_q, isr_d, imr_d, set_v, clr_v;
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic               hit_stat, hit_isr, hit_imr;

  always_comb begin
    hit_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
    hit_isr  = bus_wr && (bus_addr == ADDR_W'(REG_ISR));
    hit_imr  = bus_wr && (bus_addr == ADDR_W'(REG_IMR));

    set_v           = '0;
    set_v[IRQ_DONE] = fill_end;
    set_v[IRQ_AERR] = hit_stat;

    clr_v = req.irq_clear ? '1 : '0;
    if (hit_isr) clr_v = clr_v | wdata_lo;

    // set beats clear on the same edge
    isr_d = restart ? '0 : ((isr_q & ~clr_v) | set_v);
    imr_d = req.full ? '0 : (hit_imr ? wdata_lo : imr_q);
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(REG_STAT): rd_mux[STAT_READY]   = ready;
      ADDR_W'(REG_ISR):  rd_mux[NUM_IRQ-1:0]  = isr_q;
      ADDR_W'(REG_IMR):  rd_mux[NUM_IRQ-1:0]  = imr_q;
      default:           rd_mux               = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    isr_q <= isr_d;
    imr_q <= imr_d;
    if (restart)     rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  // one registered, masked output per interrupt lane
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    logic lane_q;
    always_ff @(posedge clk) lane_q <= isr_d[g] & imr_d[g];
    assign irq[g] = lane_q;
  end

  assign rdata    = rdata_q;
  assign isr_bits = isr_q;
  assign imr_bits = imr_q;
endmodule

// File: rtl/cipher_reset_ctrl.sv
module cipher_reset_ctrl
  import cre_pkg::*;
#(
  parameter  int DATA_W     = 64,
  parameter  int ADDR_W     = 4,
  parameter  int SBOX_DEPTH = 256,
  parameter  int SBOX_W     = 8,
  localparam int IDX_W      = $clog2(SBOX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_done,
  output logic              irq_err,
  input  logic [IDX_W-1:0]  sbox_raddr,
  output logic [SBOX_W-1:0] sbox_rdata
);
  rst_req_t           req;
  logic               restart;
  logic               fill_we, fill_end, fill_ready;
  logic [IDX_W-1:0]   fill_idx;
  logic [SBOX_W-1:0]  fill_val;
  logic [NUM_IRQ-1:0] irq_vec, isr_bits, imr_bits;
  logic               unused_wbits;

  assign unused_wbits = ^bus_wdata[CTRL_IRQ_CLR-1:NUM_IRQ];

  cre_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .hw_rst   (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .req_bits (bus_wdata[CTRL_FULL_RST:CTRL_IRQ_CLR]),
    .req      (req),
    .restart  (restart)
  );

  cre_sbox_fill #(.DEPTH(SBOX_DEPTH), .WIDTH(SBOX_W)) u_fill (
    .clk      (clk),
    .restart  (restart),
    .wr_en    (fill_we),
    .wr_idx   (fill_idx),
    .wr_val   (fill_val),
    .ready    (fill_ready),
    .fill_end (fill_end)
  );

  cre_sbox_ram #(.DEPTH(SBOX_DEPTH), .WIDTH(SBOX_W)) u_ram (
    .clk   (clk),
    .we    (fill_we),
    .waddr (fill_idx),
    .wdata (fill_val),
    .raddr (sbox_raddr),
    .rdata (sbox_rdata)
  );

  cre_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .req      (req),
    .restart  (restart),
    .fill_end (fill_end),
    .ready    (fill_ready),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[NUM_IRQ-1:0]),
    .rdata    (bus_rdata),
    .irq      (irq_vec),
    .isr_bits (isr_bits),
    .imr_bits (imr_bits)
  );

  assign irq_done = irq_vec[IRQ_DONE];
  assign irq_err  = irq_vec[IRQ_AERR];
endmodule

// File: rtl/cre_checker.sv
module cre_checker
  import cre_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_done,
  input logic               irq_err,
  input logic               fill_ready,
  input logic [NUM_IRQ-1:0] isr_bits,
  input logic [NUM_IRQ-1:0] imr_bits
);
  logic ctrl_w, heavy_w;
  assign ctrl_w  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign heavy_w = ctrl_w && (bus_wdata[CTRL_MOD_INIT] || bus_wdata[CTRL_FULL_RST]);

  p_ctrl_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADDR_W'(REG_CTRL)) |=> (bus_rdata == '0));

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (rst)
    heavy_w |=> (!fill_ready && isr_bits == '0));

  p_mask_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && bus_wdata[CTRL_MOD_INIT] && !bus_wdata[CTRL_FULL_RST]) |=> $stable(imr_bits));

  p_full_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_w && bus_wdata[CTRL_FULL_RST]) |=> (imr_bits == '0));

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_ready && !heavy_w) |=> fill_ready);

  p_stat_write_err_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(REG_STAT)) |=> isr_bits[IRQ_AERR]);

  p_err_masked_r9: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> (isr_bits[IRQ_AERR] && imr_bits[IRQ_AERR]));

  p_done_masked_r9: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> (isr_bits[IRQ_DONE] && imr_bits[IRQ_DONE]));
endmodule

bind cipher_reset_ctrl cre_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_done   (irq_done),
  .irq_err    (irq_err),
  .fill_ready (fill_ready),
  .isr_bits   (isr_bits),
  .imr_bits   (imr_bits)
);

// File: tb/cipher_reset_ctrl_bench.sv
module cipher_reset_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        irq_done, irq_err;
  logic [7:0]  sbox_raddr = '0;
  logic [7:0]  sbox_rdata;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_reset_ctrl u_cipher_reset_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_done(irq_done), .irq_err(irq_err),
    .sbox_raddr(sbox_raddr), .sbox_rdata(sbox_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_mem[DEPTH];
  int          m_idx = 0, m_sbox = -1;
  bit          m_busy = 0, m_ready = 0, m_live = 0;
  bit [1:0]    m_isr = 0, m_imr = 0;
  logic [63:0] m_rdata = '0;

  initial foreach (m_mem[i]) m_mem[i] = -1;

  always @(posedge clk) begin
    bit ctrlw, full, minit;
    bit [1:0] setv, clrv;
    logic [63:0] rv;
    ctrlw = bus_wr && bus_addr == 4'd0;
    full  = rst || (ctrlw && bus_wdata[63]);
    minit = ctrlw && bus_wdata[62] && !full;
    m_sbox = m_mem[sbox_raddr];
    if (m_busy) m_mem[m_idx] = m_idx;
    if (full || minit) begin
      m_busy = 1; m_idx = 0; m_ready = 0; m_isr = 0; m_rdata = '0; m_live = 1;
      if (full) m_imr = 0;
    end else begin
      rv = '0;
      case (bus_addr)
        4'd1: rv[0]   = m_ready;
        4'd2: rv[1:0] = m_isr;
        4'd3: rv[1:0] = m_imr;
        default: rv = '0;
      endcase
      if (bus_rd) m_rdata = rv;
      setv[0] = m_busy && m_idx == DEPTH-1;
      setv[1] = bus_wr && bus_addr == 4'd1;
      clrv = (ctrlw && bus_wdata[61]) ? 2'b11 : 2'b00;
      if (bus_wr && bus_addr == 4'd2) clrv = clrv | bus_wdata[1:0];
      m_isr = (m_isr & ~clrv) | setv;
      if (bus_wr && bus_addr == 4'd3) m_imr = bus_wdata[1:0];
      if (m_busy) begin
        m_idx++;
        if (m_idx == DEPTH) begin m_busy = 0; m_ready = 1; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk(bus_rdata === m_rdata, "R11 read data vs model", bus_rdata, m_rdata);
      chk(irq_done === (m_isr[0] & m_imr[0]), "R9 irq_done vs model", 64'(irq_done), 64'(m_isr[0] & m_imr[0]));
      chk(irq_err === (m_isr[1] & m_imr[1]), "R9 irq_err vs model", 64'(irq_err), 64'(m_isr[1] & m_imr[1]));
      if (m_sbox >= 0)
        chk(sbox_rdata === 8'(m_sbox), "R3 table data vs model", 64'(sbox_rdata), 64'(m_sbox));
    end
  end

  // ---------------- stimulus helpers (start and end at a falling edge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // edges counted from the reset request until a status read returns ready
  task automatic time_fill(output int n);
    n = 0;
    while (bus_rdata[0] !== 1'b1 && n < 400) begin
      bus_rd = 1'b1; bus_addr = 4'd1;
      @(negedge clk);
      n++;
    end
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int n;
    @(negedge clk);
    idle(3);
    chk(bus_rdata == 0 && !irq_done && !irq_err, "R1 outputs after hw reset", {bus_rdata[61:0], irq_done, irq_err}, 0);
    rst = 1'b0;
    time_fill(n);
    chk(n == 257, "R3 ready latency after hw reset", n, 257);
    rd(4'd3, v); chk(v == 0, "R1 mask word after reset", v, 0);
    rd(4'd2, v); chk(v == 1, "R12 done flag after fill", v, 1);
    chk(!irq_done, "R9 done masked off", irq_done, 0);

    for (int i = 0; i < DEPTH; i++) begin
      sbox_raddr = 8'(i);
      @(negedge clk);
      chk(sbox_rdata == 8'(i), "R3 identity entry", sbox_rdata, i);
    end

    wr(4'd3, 64'h3);
    chk(irq_done, "R9 done unmasked", irq_done, 1);

    wr(4'd0, 64'h1FFF_FFFF_FFFF_FFFF);
    rd(4'd1, v); chk(v == 1, "R2 reserved control bits ignored", v, 1);
    rd(4'd0, v); chk(v == 0, "R2 control word reads zero", v, 0);

    wr(4'd1, '1);
    chk(irq_err, "R8 status write raises error", irq_err, 1);
    rd(4'd1, v); chk(v == 1, "R8 status unchanged by write", v, 1);
    rd(4'd2, v); chk(v == 3, "R8 error flag in status word", v, 3);

    wr(4'd2, 64'h2);
    chk(!irq_err && irq_done, "R10 write-1 clears only error", {irq_err, irq_done}, 2'b01);

    wr(4'd1, '0);
    wr(4'd0, 64'h1 << 61);
    chk(!irq_done && !irq_err, "R7 interrupt clear drops outputs", {irq_done, irq_err}, 0);
    rd(4'd1, v); chk(v == 1, "R7 ready kept, no refill", v, 1);

    wr(4'd0, 64'h1 << 62);
    time_fill(n);
    chk(n == 257, "R5 ready latency after module init", n, 257);
    rd(4'd3, v); chk(v == 3, "R5 mask kept by module init", v, 3);
    rd(4'd2, v); chk(v == 1, "R12 done flag after module init", v, 1);

    // completion and write-1 clear on the same edge
    wr(4'd0, 64'h1 << 62);
    idle(255);
    wr(4'd2, 64'h1);
    chk(irq_done, "R10 set beats write-1 clear", irq_done, 1);
    rd(4'd2, v); chk(v == 1, "R10 flag survives collision", v, 1);

    // completion and interrupt clear on the same edge
    wr(4'd0, 64'h1 << 62);
    idle(255);
    wr(4'd0, 64'h1 << 61);
    chk(irq_done, "R10 set beats interrupt clear", irq_done, 1);

    wr(4'd7, 64'h0);
    rd(4'd7, v); chk(v == 0, "R11 unmapped read zero", v, 0);
    rd(4'd3, v); chk(v == 3, "R11 unmapped write ignored", v, 3);

    wr(4'd0, 64'h3 << 62);
    time_fill(n);
    chk(n == 257, "R6 ready latency with both bits", n, 257);
    rd(4'd3, v); chk(v == 0, "R6 full reset wins, mask cleared", v, 0);

    wr(4'd3, 64'h3);
    wr(4'd1, '0);
    wr(4'd0, 64'h1 << 63);
    chk(!irq_err && !irq_done, "R4 full reset clears outputs", {irq_err, irq_done}, 0);
    time_fill(n);
    chk(n == 257, "R4 ready latency after full reset", n, 257);
    rd(4'd3, v); chk(v == 0, "R4 mask cleared", v, 0);
    rd(4'd2, v); chk(v == 1, "R4 only done flag afterwards", v, 1);

    idle(2);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule